// File: doc/BRIEF.md
# Edge-Triggered Interrupt Flag with Separate Arm and Enable

This block is a single interrupt channel for a pin-sensing peripheral. It brings a raw external pin into the clock domain through a chain of flip-flops. It then watches the synchronized level for a selectable transition: falling, rising, either, or none. When the channel is armed, a matching transition latches a sticky event flag. The flag drives the interrupt request line only while the channel is enabled.

Arming decides whether an edge can be recorded at all. Enabling decides whether a recorded event reaches the processor. As a result, a disabled channel keeps its event and raises the request as soon as it is enabled. A channel that is armed but not enabled can be polled by software without causing an interrupt. Software clears the flag by writing a one to its bit through a simple write strobe; writing a zero does nothing. The request therefore stays up until the handler removes its cause.

Top module: `edge_irq_flag`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `flag_o` and `irq_o` are 0.
- R2: With `edge_mode` = 2'b00, a 1-to-0 change of `pin_raw` on an armed input channel sets `flag_o`. The flag is still 0 two clocks after the change and is 1 after the third rising clock edge (SYNC_STAGES+1 clocks). A 0-to-1 change does not set it.
- R3: With `edge_mode` = 2'b01, only a 0-to-1 change of `pin_raw` sets `flag_o`, with the same latency as R2.
- R4: With `edge_mode` = 2'b10, both directions of change set `flag_o`. With `edge_mode` = 2'b11, neither direction sets it.
- R5: While `arm` is 0, no pin transition sets `flag_o`.
- R6: A set flag is held while `enable` is 0, and `irq_o` stays 0. Once `enable` goes to 1, `irq_o` is 1 after the next rising clock edge.
- R7: A cycle with `wr_en` = 1 and bit FLAG_BIT (default bit 0) of `wr_data` = 1 clears `flag_o` at the next clock edge. A write with that bit at 0 leaves the flag unchanged.
- R8: Once raised, `irq_o` stays 1 for as long as the flag is not cleared and `enable` stays 1, whatever the pin does.
- R9: If a detected armed edge and a clearing write fall in the same cycle, the flag ends up set.
- R10: While `pin_is_output` is 1, no pin transition sets `flag_o`.
- R11: `irq_o` is a registered output equal to the next flag value ANDed with `enable`. It falls on the same clock edge at which the flag is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 1 | Asynchronous external pin |
| pin_is_output | input | 1 | 1 when the pin is configured as an output, which blocks detection |
| edge_mode | input | 2 | 00 falling, 01 rising, 10 both, 11 none |
| arm | input | 1 | Lets a detected edge set the flag |
| enable | input | 1 | Lets the flag drive the request |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Write data; a 1 in bit FLAG_BIT clears the flag |
| flag_o | output | 1 | Event flag, readable by software |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench runs every combination of edge mode, transition direction, arm, enable and pin direction, and computes each expected flag and request value arithmetically. At the clock boundary on either side of the flag's arrival, it checks that the synchronizer latency is exactly three clocks. A design with one stage too few or too many would show the flag a cycle early or late. An armed but disabled event must sit quietly and then fire as soon as enable is raised; a design that drops disabled events, or ignores the enable, fails here. A clearing write is placed in the exact cycle the edge is detected, and a design that lets the clear win loses that event.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_OFF  = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/irqf_sync.sv
module irqf_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= IDLE;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{IDLE}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irqf_edge.sv
module irqf_edge
  import irqf_pkg::*;
#(
  parameter logic IDLE = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       level,
  input  edge_mode_e mode,
  input  logic       pin_out,
  output logic       hit
);
  logic prev;
  logic rise, fall, cand;

  always_ff @(posedge clk) begin
    if (rst) prev <= IDLE;
    else     prev <= level;
  end

  assign rise = level & ~prev;
  assign fall = ~level & prev;

  always_comb begin
    case (mode)
      EDGE_FALL: cand = fall;
      EDGE_RISE: cand = rise;
      EDGE_BOTH: cand = rise | fall;
      default:   cand = 1'b0;
    endcase
  end

  // an output-configured pin never reports an event
  assign hit = cand & ~pin_out;
endmodule

// File: rtl/irqf_flag.sv
module irqf_flag (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic arm,
  input  logic enable,
  input  logic clr_req,
  output logic flag_q,
  output logic irq_q
);
  logic flag_d;

  // a new event takes priority over a simultaneous clear
  assign flag_d = (hit & arm) | (flag_q & ~clr_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d & enable;
    end
  end
endmodule

// File: rtl/edge_irq_flag.sv
module edge_irq_flag
  import irqf_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter int   DATA_W      = 8,
  parameter int   FLAG_BIT    = 0,
  parameter logic PIN_IDLE    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_raw,
  input  logic              pin_is_output,
  input  logic [1:0]        edge_mode,
  input  logic              arm,
  input  logic              enable,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              flag_o,
  output logic              irq_o
);
  localparam int LATENCY = SYNC_STAGES + 1;

  logic       pin_sync;
  logic       edge_hit;
  logic       clr_req;
  edge_mode_e mode_e;

  assign mode_e  = edge_mode_e'(edge_mode);
  assign clr_req = wr_en & wr_data[FLAG_BIT];

  irqf_sync #(.STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) sync_i (
    .clk(clk), .rst(rst), .d(pin_raw), .q(pin_sync)
  );

  irqf_edge #(.IDLE(PIN_IDLE)) edge_i (
    .clk(clk), .rst(rst), .level(pin_sync), .mode(mode_e),
    .pin_out(pin_is_output), .hit(edge_hit)
  );

  irqf_flag flag_i (
    .clk(clk), .rst(rst), .hit(edge_hit), .arm(arm), .enable(enable),
    .clr_req(clr_req), .flag_q(flag_o), .irq_q(irq_o)
  );

  initial begin
    if (FLAG_BIT >= DATA_W || SYNC_STAGES < 1 || LATENCY < 2)
      $error("edge_irq_flag: bad parameters");
  end
endmodule

// File: rtl/edge_irq_flag_chk.sv
module edge_irq_flag_chk (
  input logic clk,
  input logic rst,
  input logic arm,
  input logic enable,
  input logic pin_is_output,
  input logic clr_req,
  input logic hit,
  input logic flag_o,
  input logic irq_o
);
  a_r5_set_needs_arm: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past(arm));

  a_r10_output_blocks: assert property (@(posedge clk) disable iff (rst)
    (!flag_o && pin_is_output) |=> !flag_o);

  a_r7_clear_works: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !hit) |=> !flag_o);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (hit && arm) |=> flag_o);

  a_r6_flag_held: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_req) |=> flag_o);

  a_r11_irq_implies_flag: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o);

  a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(enable));

  a_r8_irq_persists: assert property (@(posedge clk) disable iff (rst)
    (flag_o && enable && !clr_req) |=> irq_o);
endmodule

bind edge_irq_flag edge_irq_flag_chk chk_i (
  .clk(clk), .rst(rst), .arm(arm), .enable(enable),
  .pin_is_output(pin_is_output), .clr_req(clr_req), .hit(edge_hit),
  .flag_o(flag_o), .irq_o(irq_o)
);

// File: tb/edge_irq_flag_tb_top.sv
module edge_irq_flag_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_raw = 1'b1;
  logic       pin_is_output = 1'b0;
  logic [1:0] edge_mode = 2'b00;
  logic       arm = 1'b0;
  logic       enable = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       flag_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  edge_irq_flag dut_i (
    .clk(clk), .rst(rst), .pin_raw(pin_raw), .pin_is_output(pin_is_output),
    .edge_mode(edge_mode), .arm(arm), .enable(enable), .wr_en(wr_en),
    .wr_data(wr_data), .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] val);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 8'h00;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    string tag;
    logic  exp;
    logic  matched;
    repeat (3) @(negedge clk);
    check("R1", flag_o, 1'b0, "flag in reset");
    check("R1", irq_o, 1'b0, "irq in reset");
    rst = 1'b0;
    @(negedge clk);
    check("R1", flag_o, 1'b0, "flag after reset");
    check("R1", irq_o, 1'b0, "irq after reset");

    for (int m = 0; m < 4; m++) begin
      for (int pol = 0; pol < 2; pol++) begin
        for (int a = 0; a < 2; a++) begin
          for (int e = 0; e < 2; e++) begin
            for (int d = 0; d < 2; d++) begin
              // settle the pin at the starting level with the channel disarmed
              arm = 1'b0; enable = 1'b0; pin_is_output = 1'b0;
              pin_raw = (pol == 1) ? 1'b0 : 1'b1;
              repeat (4) @(negedge clk);
              write_reg(8'h01);
              // pol 0: falling edge, pol 1: rising edge
              if (pol == 0) matched = (m == 0) || (m == 2);
              else          matched = (m == 1) || (m == 2);
              exp = matched && (a == 1) && (d == 0);
              if (d == 1)      tag = "R10";
              else if (a == 0) tag = "R5";
              else if (m == 0) tag = "R2";
              else if (m == 1) tag = "R3";
              else             tag = "R4";
              edge_mode = m[1:0];
              arm = a[0];
              enable = e[0];
              pin_is_output = d[0];
              pin_raw = ~pin_raw;
              @(posedge clk);
              @(posedge clk);
              @(negedge clk);
              if (exp) check(tag, flag_o, 1'b0, "flag before latency");
              @(negedge clk);
              check(tag, flag_o, exp, "flag after latency");
              check("R11", irq_o, exp & e[0], "irq with flag");
              if (exp && e == 0) begin
                @(negedge clk);
                check("R6", flag_o, 1'b1, "flag held while disabled");
                check("R6", irq_o, 1'b0, "irq low while disabled");
                enable = 1'b1;
                @(negedge clk);
                check("R6", irq_o, 1'b1, "irq after enable");
              end
              if (exp) begin
                pin_raw = ~pin_raw;
                repeat (4) @(negedge clk);
                check("R8", irq_o, 1'b1, "irq persists");
                write_reg(8'hFE);
                check("R7", flag_o, 1'b1, "write 0 keeps flag");
                write_reg(8'h01);
                check("R7", flag_o, 1'b0, "write 1 clears flag");
                check("R11", irq_o, 1'b0, "irq falls with clear");
              end
            end
          end
        end
      end
    end

    // edge and clear in the same cycle
    arm = 1'b0; enable = 1'b0; pin_is_output = 1'b0; pin_raw = 1'b1;
    repeat (4) @(negedge clk);
    write_reg(8'h01);
    edge_mode = 2'b10; arm = 1'b1; enable = 1'b1;
    pin_raw = 1'b0;
    repeat (4) @(negedge clk);
    check("R9", flag_o, 1'b1, "first event set");
    pin_raw = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h01;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
    check("R9", flag_o, 1'b1, "set wins over clear");
    check("R9", irq_o, 1'b1, "irq kept on set-wins");
    write_reg(8'h01);
    check("R7", flag_o, 1'b0, "clear after set-wins");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule